// File: doc/BRIEF.md
# Reference Clock Output Gating and Power-Down Control

This block decides, cycle by cycle, which of four buffered clock outputs may run, and when the phase-locked loop that feeds them is switched on. It combines a power-good input, an active-low enable pin for each output, an enable bit for each output supplied by a configuration register, and a lock indication from the loop. Outputs are held stopped until the loop reports lock, unless the loop is bypassed. In bypass mode the loop stays off and the outputs run directly from the reference.

On the first rising edge of power-good after reset, the block captures two three-level strap inputs. One selects the loop mode and the other selects the bus address. Later low periods of power-good stop everything. Later high periods restart it and do not capture the straps again. Software fields can replace the captured loop mode, and they can also pick the loop frequency setting. Each software field has its own enable. The run/stop decision for each output changes only on a falling edge of the reference clock, so the analog driver downstream never sees a shortened pulse.

Top module: `refclk_out_gate`

## Requirements
- R1: While `pwrGood` is low, `outRun` is all zeros and `pllEn` is 0.
- R2: With power-good active and the clock path allowed (see R4), `outRun[i]` is 1 exactly when `oeRegBits[i]` is 1 and `oePinN[i]` is 0. A register bit of 0 stops that output whatever its pin says.
- R3: The straps are captured only on the first high `pwrGood` after reset. Strap changes and later power-good cycles leave `addrSel` and the strapped mode unchanged. `addrSel` encodes the strap as 00 to 00, 01 to 01, and 10 or 11 to 10.
- R4: In a loop mode (`pllMode` not 01), `outRun` stays zero until `pllLocked` is 1. In bypass mode (`pllMode` = 01), `pllEn` is 0 and the outputs run without lock.
- R5: The mode strap is decoded as 00 (low) to `pllMode` 00 (low bandwidth), 01 (mid) to 01 (bypass), and 10 or 11 (high) to 11 (high bandwidth). `pllEn` is 1 in both loop modes while power-good is active.
- R6: When `swModeEn` is 1, `pllMode` follows `swMode`, decoded as in R5. When it is 0, `pllMode` shows the captured strap mode.
- R7: When `swFreqEn` is 0, `freqSel` is 00. When it is 1 and `swFreq` is 00, 01 or 10, `freqSel` equals `swFreq`.
- R8: When `swFreqEn` is 1 and `swFreq` is the reserved code 11, `freqSel` keeps the value it had on the previous cycle.
- R9: A change on `oePinN` reaches `outRun` on the falling reference edge that follows the second rising edge after the change. This is within 1 to 3 reference cycles.
- R10: `outRun` changes only on falling edges of `refClk`. A change of `oeRegBits`, `pllLocked` or `pwrGood` made after a rising edge appears at the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Power-good; low requests power-down |
| pllLocked | input | 1 | Lock indication from the loop |
| strapMode | input | 2 | Three-level mode strap: 00 low, 01 mid, 1x high |
| strapAddr | input | 2 | Three-level address strap: 00 low, 01 mid, 1x high |
| oePinN | input | 4 | Active-low enable pin for each output |
| oeRegBits | input | 4 | Register enable bit for each output |
| swModeEn | input | 1 | Lets `swMode` replace the strapped mode |
| swMode | input | 2 | Software loop-mode code |
| swFreqEn | input | 1 | Lets `swFreq` select the frequency |
| swFreq | input | 2 | Frequency code: 00 100 MHz, 01 50 MHz, 10 125 MHz, 11 reserved |
| outRun | output | 4 | Run (1) or stop low/low (0) for each output |
| pllEn | output | 1 | Loop power enable |
| pllMode | output | 2 | Effective loop mode: 00 low BW, 01 bypass, 11 high BW |
| freqSel | output | 2 | Effective frequency code |
| addrSel | output | 2 | Captured address selection |

## Verification
The bench goes after the capture-once rule. It changes the straps, then cycles power-good. A design that captured on every rise would show a new `addrSel` and mode.

It walks the lock gate in both loop and bypass modes. A wrong gate would either leak clocks before lock or hold outputs stopped in bypass.

The reserved frequency code is applied after a valid code and also straight after the enable rises. A design that passed the code through would show 11, and one that held a stale value would not reset to 00.

The pin latency and the falling-edge-only update are sampled at half-cycle points. A design with a missing synchroniser stage, or a run register clocked on the rising edge, would change one sample early.

// File: rtl/refclk_gate_pkg.sv
package refclk_gate_pkg;

  localparam logic [1:0] MODE_LOW_BW  = 2'b00;
  localparam logic [1:0] MODE_BYPASS  = 2'b01;
  localparam logic [1:0] MODE_HIGH_BW = 2'b11;
  localparam logic [1:0] FREQ_RSVD    = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic latchStraps;
    logic outGate;
  } ctlStrobe_t;

  // three-level code (00 low, 01 mid, 1x high) to loop mode
  function automatic logic [1:0] decodeMode(input logic [1:0] code);
    if (code[1])      return MODE_HIGH_BW;
    else if (code[0]) return MODE_BYPASS;
    else              return MODE_LOW_BW;
  endfunction

  // three-level code to address index 0..2
  function automatic logic [1:0] decodeAddr(input logic [1:0] code);
    return code[1] ? 2'b10 : {1'b0, code[0]};
  endfunction

endpackage

// File: rtl/refclk_out_gate_ctrl.sv
module refclk_out_gate_ctrl
  import refclk_gate_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       pllLocked,
  input  logic       effBypass,
  output ctlStrobe_t strobe,
  output logic       pllEn
);

  logic pgSeen;
  logic active;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)        pgSeen <= 1'b0;
    else if (pwrGood) pgSeen <= 1'b1;
  end

  // active only once the straps are already held
  assign active = pwrGood && pgSeen;

  always_comb begin
    strobe.latchStraps = pwrGood && !pgSeen;
    strobe.outGate     = active && (effBypass || pllLocked);
    pllEn              = active && !effBypass;
  end

endmodule

// File: rtl/refclk_out_gate_dp.sv
module refclk_out_gate_dp
  import refclk_gate_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [1:0]         strapMode,
  input  logic [1:0]         strapAddr,
  input  logic [NUM_OUT-1:0] oePinN,
  input  logic [NUM_OUT-1:0] oeRegBits,
  input  logic               swModeEn,
  input  logic [1:0]         swMode,
  input  logic               swFreqEn,
  input  logic [1:0]         swFreq,
  output logic               effBypass,
  output logic [1:0]         pllMode,
  output logic [1:0]         freqSel,
  output logic [1:0]         addrSel,
  output logic [NUM_OUT-1:0] outRun
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_OUT-1:0] syncQ [SYNC_STAGES];
  logic [NUM_OUT-1:0] pinSync;
  logic [1:0]         latchedMode;
  logic [1:0]         latchedAddr;
  logic [1:0]         freqHeld;
  logic               runQ [NUM_OUT];

  // enable pin synchroniser, reset to "disabled"
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '1;
        else       syncQ[s] <= oePinN;
      end
    end else begin : g_next
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '1;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end
  assign pinSync = syncQ[LAST_STAGE];

  // straps captured once
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      latchedMode <= MODE_LOW_BW;
      latchedAddr <= 2'b00;
    end else if (strobe.latchStraps) begin
      latchedMode <= decodeMode(strapMode);
      latchedAddr <= decodeAddr(strapAddr);
    end
  end

  assign pllMode   = swModeEn ? decodeMode(swMode) : latchedMode;
  assign effBypass = (pllMode == MODE_BYPASS);
  assign addrSel   = latchedAddr;

  // frequency selection with reserved code holding the last value
  always_comb begin
    if (!swFreqEn)               freqSel = 2'b00;
    else if (swFreq != FREQ_RSVD) freqSel = swFreq;
    else                          freqSel = freqHeld;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) freqHeld <= 2'b00;
    else       freqHeld <= freqSel;
  end

  // run/stop registers update on the falling edge only
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(negedge refClk or negedge rstN) begin
      if (!rstN) runQ[i] <= 1'b0;
      else       runQ[i] <= strobe.outGate && oeRegBits[i] && !pinSync[i];
    end
    assign outRun[i] = runQ[i];
  end

endmodule

// File: rtl/refclk_out_gate.sv
module refclk_out_gate
  import refclk_gate_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic               pllLocked,
  input  logic [1:0]         strapMode,
  input  logic [1:0]         strapAddr,
  input  logic [NUM_OUT-1:0] oePinN,
  input  logic [NUM_OUT-1:0] oeRegBits,
  input  logic               swModeEn,
  input  logic [1:0]         swMode,
  input  logic               swFreqEn,
  input  logic [1:0]         swFreq,
  output logic [NUM_OUT-1:0] outRun,
  output logic               pllEn,
  output logic [1:0]         pllMode,
  output logic [1:0]         freqSel,
  output logic [1:0]         addrSel
);

  ctlStrobe_t strobe;
  logic       effBypass;

  refclk_out_gate_ctrl ctrl_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .pwrGood   (pwrGood),
    .pllLocked (pllLocked),
    .effBypass (effBypass),
    .strobe    (strobe),
    .pllEn     (pllEn)
  );

  refclk_out_gate_dp #(
    .NUM_OUT     (NUM_OUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .strapMode (strapMode),
    .strapAddr (strapAddr),
    .oePinN    (oePinN),
    .oeRegBits (oeRegBits),
    .swModeEn  (swModeEn),
    .swMode    (swMode),
    .swFreqEn  (swFreqEn),
    .swFreq    (swFreq),
    .effBypass (effBypass),
    .pllMode   (pllMode),
    .freqSel   (freqSel),
    .addrSel   (addrSel),
    .outRun    (outRun)
  );

endmodule

// File: rtl/refclk_out_gate_chk.sv
module refclk_out_gate_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               refClk,
  input logic               rstN,
  input logic               pwrGood,
  input logic               pllLocked,
  input logic [NUM_OUT-1:0] oeRegBits,
  input logic               swFreqEn,
  input logic [1:0]         swFreq,
  input logic [NUM_OUT-1:0] outRun,
  input logic               pllEn,
  input logic [1:0]         pllMode,
  input logic [1:0]         freqSel,
  input logic [1:0]         addrSel
);

  logic seenA, seenB;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      seenA <= 1'b0;
      seenB <= 1'b0;
    end else begin
      if (pwrGood) seenA <= 1'b1;
      seenB <= seenA;
    end
  end

  AST_PG_LOW_STOPS: assert property (@(posedge refClk) disable iff (!rstN)
    !pwrGood |-> (outRun == '0 && !pllEn)); // R1

  AST_REG_BIT_FORCES_STOP: assert property (@(posedge refClk) disable iff (!rstN)
    (outRun & ~oeRegBits) == '0); // R2

  AST_STRAP_CAPTURED_ONCE: assert property (@(posedge refClk) disable iff (!rstN)
    seenB |-> $stable(addrSel)); // R3

  AST_NO_CLOCK_BEFORE_LOCK: assert property (@(posedge refClk) disable iff (!rstN)
    (pllMode != 2'b01 && !pllLocked) |-> outRun == '0); // R4

  AST_BYPASS_LOOP_OFF: assert property (@(posedge refClk) disable iff (!rstN)
    (pllMode == 2'b01) |-> !pllEn); // R4

  AST_RSVD_FREQ_HOLDS: assert property (@(posedge refClk) disable iff (!rstN)
    (swFreqEn && swFreq == 2'b11 && $past(swFreqEn)) |-> $stable(freqSel)); // R8

  AST_FREQ_NEVER_RSVD: assert property (@(posedge refClk) disable iff (!rstN)
    freqSel != 2'b11); // R7

endmodule

bind refclk_out_gate refclk_out_gate_chk #(.NUM_OUT(NUM_OUT)) chk_i (
  .refClk    (refClk),
  .rstN      (rstN),
  .pwrGood   (pwrGood),
  .pllLocked (pllLocked),
  .oeRegBits (oeRegBits),
  .swFreqEn  (swFreqEn),
  .swFreq    (swFreq),
  .outRun    (outRun),
  .pllEn     (pllEn),
  .pllMode   (pllMode),
  .freqSel   (freqSel),
  .addrSel   (addrSel)
);

// File: tb/refclk_out_gate_tb_top.sv
module refclk_out_gate_tb_top;

  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGood = 1'b0;
  logic       pllLocked = 1'b0;
  logic [1:0] strapMode = 2'b00;
  logic [1:0] strapAddr = 2'b00;
  logic [3:0] oePinN = 4'h0;
  logic [3:0] oeRegBits = 4'hF;
  logic       swModeEn = 1'b0;
  logic [1:0] swMode = 2'b00;
  logic       swFreqEn = 1'b0;
  logic [1:0] swFreq = 2'b00;
  logic [3:0] outRun;
  logic       pllEn;
  logic [1:0] pllMode;
  logic [1:0] freqSel;
  logic [1:0] addrSel;

  int nChecks = 0;
  int nErr = 0;

  always #4 refClk = ~refClk;

  refclk_out_gate dut_i (
    .refClk(refClk), .rstN(rstN), .pwrGood(pwrGood), .pllLocked(pllLocked),
    .strapMode(strapMode), .strapAddr(strapAddr), .oePinN(oePinN),
    .oeRegBits(oeRegBits), .swModeEn(swModeEn), .swMode(swMode),
    .swFreqEn(swFreqEn), .swFreq(swFreq), .outRun(outRun), .pllEn(pllEn),
    .pllMode(pllMode), .freqSel(freqSel), .addrSel(addrSel)
  );

  function automatic logic [1:0] modeOf(input logic [1:0] c);
    case (c)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] addrOf(input logic [1:0] c);
    case (c)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [3:0] runOf(input logic pg, input logic lk,
      input logic [1:0] md, input logic [3:0] rb, input logic [3:0] pn);
    if (!pg) return 4'h0;
    if (md != 2'b01 && !lk) return 4'h0;
    return rb & ~pn;
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic powerOn(input logic [1:0] ms, input logic [1:0] as);
    tick();
    rstN = 1'b0; pwrGood = 1'b0; swModeEn = 1'b0; swFreqEn = 1'b0;
    strapMode = ms; strapAddr = as;
    tick();
    rstN = 1'b1;
    tick();
    pwrGood = 1'b1;
    tick(3); #5;
  endtask

  initial begin
    repeat (200000) @(posedge refClk);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [1:0] latchedExp;
    logic [1:0] heldExp;
    void'($urandom(32'd20240611));
    tick(2);
    rstN = 1'b1;
    tick(2); #5;
    chk("R1 reset run", {4'h0, outRun}, 8'h00);
    chk("R1 reset pllEn", {7'h0, pllEn}, 8'h00);

    // first power-good: high strap, mid address, no lock
    tick();
    strapMode = 2'b10; strapAddr = 2'b01; pwrGood = 1'b1;
    tick(3); #5;
    chk("R5 high strap", {6'h0, pllMode}, 8'h03);
    chk("R3 addr capture", {6'h0, addrSel}, 8'h01);
    chk("R5 pllEn loop", {7'h0, pllEn}, 8'h01);
    chk("R4 blocked no lock", {4'h0, outRun}, 8'h00);
    tick(); pllLocked = 1'b1;
    tick(2); #5;
    chk("R2 all running", {4'h0, outRun}, 8'h0F);

    // straps change, power cycle, no re-capture
    tick(); strapMode = 2'b00; strapAddr = 2'b10; pwrGood = 1'b0;
    tick(3); #5;
    chk("R1 pd run", {4'h0, outRun}, 8'h00);
    chk("R1 pd pllEn", {7'h0, pllEn}, 8'h00);
    tick(); pwrGood = 1'b1;
    tick(3); #5;
    chk("R3 mode kept", {6'h0, pllMode}, 8'h03);
    chk("R3 addr kept", {6'h0, addrSel}, 8'h01);
    chk("R1 restart run", {4'h0, outRun}, 8'h0F);

    // truth table
    tick(); oeRegBits = 4'b1010; oePinN = 4'b0110;
    tick(3); #5;
    chk("R2 mixed", {4'h0, outRun}, 8'h08);

    // software mode override
    tick(); oeRegBits = 4'hF; oePinN = 4'h0; pllLocked = 1'b0;
    swModeEn = 1'b1; swMode = 2'b01;
    tick(3); #5;
    chk("R6 sw bypass", {6'h0, pllMode}, 8'h01);
    chk("R4 bypass pllEn", {7'h0, pllEn}, 8'h00);
    chk("R4 bypass runs unlocked", {4'h0, outRun}, 8'h0F);
    tick(); swMode = 2'b10;
    tick(3); #5;
    chk("R6 sw code 10", {6'h0, pllMode}, 8'h03);
    chk("R4 loop unlocked blocked", {4'h0, outRun}, 8'h00);
    tick(); swModeEn = 1'b0; swMode = 2'b00; pllLocked = 1'b1;
    tick(3); #5;
    chk("R6 sw off", {6'h0, pllMode}, 8'h03);

    // frequency select
    tick(); swFreq = 2'b10;
    tick(2); #5;
    chk("R7 freq disabled", {6'h0, freqSel}, 8'h00);
    tick(); swFreqEn = 1'b1;
    tick(2); #5;
    chk("R7 freq 125", {6'h0, freqSel}, 8'h02);
    tick(); swFreq = 2'b11;
    tick(2); #5;
    chk("R8 reserved holds", {6'h0, freqSel}, 8'h02);
    tick(); swFreq = 2'b01;
    tick(); #5;
    chk("R7 freq 50", {6'h0, freqSel}, 8'h01);
    tick(); swFreqEn = 1'b0; swFreq = 2'b11;
    tick(); #5;
    chk("R7 off again", {6'h0, freqSel}, 8'h00);
    tick(); swFreqEn = 1'b1;
    tick(2); #5;
    chk("R8 reserved after enable", {6'h0, freqSel}, 8'h00);
    tick(); swFreqEn = 1'b0; swFreq = 2'b00;

    // pin latency
    tick(2); oePinN = 4'b0001;
    #5;
    chk("R9 before first edge", {4'h0, outRun}, 8'h0F);
    tick(); #5;
    chk("R9 after one edge", {4'h0, outRun}, 8'h0F);
    tick(); #5;
    chk("R9 after two edges", {4'h0, outRun}, 8'h0E);

    // falling-edge-only update
    tick(); oeRegBits = 4'b0111;
    #2;
    chk("R10 before fall", {4'h0, outRun}, 8'h0E);
    #3;
    chk("R10 after fall", {4'h0, outRun}, 8'h06);
    tick(); pllLocked = 1'b0;
    #2;
    chk("R10 lock before fall", {4'h0, outRun}, 8'h06);
    #3;
    chk("R10 lock after fall", {4'h0, outRun}, 8'h00);
    tick(); pllLocked = 1'b1; oeRegBits = 4'hF; oePinN = 4'h0;

    // every strap code on a fresh power-on
    for (int c = 0; c < 4; c++) begin
      powerOn(c[1:0], c[1:0]);
      chk("R5 strap decode", {6'h0, pllMode}, {6'h0, modeOf(c[1:0])});
      chk("R3 addr decode", {6'h0, addrSel}, {6'h0, addrOf(c[1:0])});
      chk("R5 pllEn per mode", {7'h0, pllEn}, {7'h0, (c != 1)});
    end
    latchedExp = 2'b11;
    heldExp = 2'b00;

    // constrained random
    for (int it = 0; it < 300; it++) begin
      logic [1:0] mExp;
      logic [1:0] fExp;
      tick();
      pwrGood   = ($urandom_range(3) != 0);
      pllLocked = ($urandom_range(4) != 0);
      oeRegBits = 4'($urandom);
      oePinN    = 4'($urandom);
      swModeEn  = 1'($urandom);
      swMode    = 2'($urandom);
      swFreqEn  = 1'($urandom);
      swFreq    = 2'($urandom);
      tick(3); #5;
      mExp = swModeEn ? modeOf(swMode) : latchedExp;
      if (!swFreqEn) begin heldExp = 2'b00; fExp = 2'b00; end
      else if (swFreq != 2'b11) begin heldExp = swFreq; fExp = swFreq; end
      else fExp = heldExp;
      chk("R6 random mode", {6'h0, pllMode}, {6'h0, mExp});
      chk("R2 random run", {4'h0, outRun},
          {4'h0, runOf(pwrGood, pllLocked, mExp, oeRegBits, oePinN)});
      chk("R4 random pllEn", {7'h0, pllEn}, {7'h0, (pwrGood && mExp != 2'b01)});
      chk("R8 random freq", {6'h0, freqSel}, {6'h0, fExp});
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule